// File: doc/BRIEF.md
# Time-Shared Serial Result Transmitter

This block sends a 32-bit result word over one serial data line that as many as eight devices share. Each device owns a 32-cycle slot chosen by its 3-bit hardwired address. A load strobe hands in a 24-bit conversion result together with four status flags. The block then gives a one-cycle active-low ready pulse. After that pulse, a sequence of `32 × (share + 1)` serial clock cycles follows, and each device drives the line only in its own slot. The word goes out MSB first: the 24 result bits, then a status byte. Inside that status byte the device address comes first so that a receiver can tell which device a word came from.

The block runs in one clock domain, and one clock period is one serial-clock period. The serial clock output is the block clock itself, so every output bit changes on the rising edge and can be captured on the falling edge. Three framing signals are produced: the ready pulse, an active-low frame sync that covers this device's own slot, and a latch pulse that marks every sixteenth bit. A result that arrives while a transfer is running is held back, and it is sent as soon as that transfer ends.

Top module: `rtx_top`

## Requirements
- R1: After reset, `drdy_n_o` and `fsync_n_o` are 1, and `sdo_oe_o` and `latch_o` are 0.
- R2: When `res_load_i` is sampled high while the block is idle, `drdy_n_o` is low in the next cycle only, for exactly one cycle.
- R3: The word is sent MSB first as bits 31..0. Bits 31..8 hold the result. Bits 7..0 hold the status byte {addr[2], addr[1], addr[0], `dvalid_i`, `ovr_i`, `lpwr_i`, `filt_ok_i`, 0}.
- R4: Cycle 0 is the first cycle after the ready cycle. A device with address a drives `sdo_oe_o` in cycles 32a to 32a+31. One transfer lasts 32 × (share+1) cycles, after which the block goes back to idle.
- R5: `fsync_n_o` is low in exactly the 32 cycles of this device's own slot, and at no other time.
- R6: `latch_o` is high for one cycle on the 16th and on the 32nd bit of the own slot (local bit indices 15 and 31), and it is low at all other times.
- R7: While `ser_en_n_i` is 1, `sdo_oe_o` is 0. The timing of the data and of the framing signals does not change.
- R8: If the address is greater than the share value, the device never drives the line, and `fsync_n_o` stays high for the whole transfer.
- R9: A load that arrives during a transfer, including its ready cycle and its last cycle, is held. If several such loads arrive, the latest one is kept. The next ready cycle comes directly after the last cycle of the current transfer.
- R10: `share_i`, `dev_addr_i` and the result are sampled when a transfer is started. Changes to them during that transfer have no effect on it.
- R11: `ser_clk_o` follows the block clock, so that `sdo_o` is stable while `ser_clk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one serial-clock period |
| rst | input | 1 | Synchronous active-high reset |
| res_i | input | 24 | Conversion result |
| res_load_i | input | 1 | Load strobe for result and flags |
| dvalid_i | input | 1 | Data-valid status flag |
| ovr_i | input | 1 | Overrange status flag |
| lpwr_i | input | 1 | Low-power status flag |
| filt_ok_i | input | 1 | Filter-settled status flag |
| dev_addr_i | input | 3 | Hardwired slot address |
| share_i | input | 3 | Number of sharing devices minus one |
| ser_en_n_i | input | 1 | Active-low serial output enable |
| ser_clk_o | output | 1 | Serial clock |
| drdy_n_o | output | 1 | Active-low one-cycle ready pulse |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable for the serial data line |
| fsync_n_o | output | 1 | Active-low frame sync for the own slot |
| latch_o | output | 1 | Pulse on every sixteenth bit |

## Verification
Directed frames use fixed result and flag values together with chosen address and share pairs: address 0 with share 0, address 3 at the far end of four slots, address 5 beyond the share count, and a frame with the output disabled. These frames separate errors in slot position, in frame length, in status packing order and in the enable gating. Loads are injected in the middle of a transfer and on its last cycle, which tests both that the latest held result wins and that the next ready cycle follows with no gap. A mid-frame change of the share and address inputs shows that they are sampled when the transfer starts. Seeded random frames then vary data, flags, address, share and enable together. This catches bit-order and slot errors that depend on the data values.

// File: rtl/rtx_pkg.sv
`timescale 1ns/1ps
package rtx_pkg;
    localparam int RES_W      = 24;
    localparam int FLAG_W     = 4;
    localparam int ADDR_W     = 3;
    localparam int STAT_W     = ADDR_W + FLAG_W + 1;
    localparam int WORD_W     = RES_W + STAT_W;
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int CNT_W      = BIT_W + ADDR_W;
    localparam int LATCH_SPAN = 16;
    localparam int LATCH_W    = $clog2(LATCH_SPAN);

    typedef struct packed {
        logic dvalid;
        logic ovr;
        logic lpwr;
        logic filt_ok;
    } flags_t;

    typedef struct packed {
        logic [RES_W-1:0] res;
        flags_t           flags;
    } sample_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SEND  = 2'd2
    } seq_state_t;

    function automatic logic [WORD_W-1:0] build_word(input sample_t s,
                                                     input logic [ADDR_W-1:0] addr);
        return {s.res, addr, s.flags, 1'b0};
    endfunction
endpackage

// File: rtl/rtx_load_buf.sv
`timescale 1ns/1ps
module rtx_load_buf
    import rtx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  sample_t sample_i,
    input  logic    take_i,
    output logic    next_vld_o,
    output sample_t next_o
);
    logic    pend_vld_q;
    sample_t pend_q;

    assign next_vld_o = load_i | pend_vld_q;
    assign next_o     = load_i ? sample_i : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld_q <= 1'b0;
            pend_q     <= '0;
        end else if (take_i) begin
            pend_vld_q <= 1'b0;
        end else if (load_i) begin
            pend_vld_q <= 1'b1;
            pend_q     <= sample_i;
        end
    end

    // R9
    hold_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !take_i) |=> pend_vld_q);

    // R9
    pend_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_vld_q && !take_i && !load_i) |=> (pend_vld_q && $stable(pend_q)));
endmodule

// File: rtl/rtx_slot_seq.sv
`timescale 1ns/1ps
module rtx_slot_seq
    import rtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              next_vld_i,
    input  logic [ADDR_W-1:0] share_i,
    output logic              take_o,
    output logic              drdy_n_o,
    output logic              sending_o,
    output logic [CNT_W-1:0]  cnt_o
);
    seq_state_t        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] share_q;
    logic [CNT_W-1:0]  last;
    logic              at_end;

    assign last   = {share_q, {BIT_W{1'b1}}};
    assign at_end = (st_q == ST_SEND) && (cnt_q == last);
    assign take_o = next_vld_i && ((st_q == ST_IDLE) || at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            share_q <= '0;
        end else if (take_o) begin
            st_q    <= ST_READY;
            share_q <= share_i;
            cnt_q   <= '0;
        end else begin
            case (st_q)
                ST_READY: begin
                    st_q  <= ST_SEND;
                    cnt_q <= '0;
                end
                ST_SEND: begin
                    if (at_end) st_q <= ST_IDLE;
                    else        cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign drdy_n_o  = (st_q != ST_READY);
    assign sending_o = (st_q == ST_SEND);
    assign cnt_o     = cnt_q;

    // R2
    drdy_single_chk: assert property (@(posedge clk) disable iff (rst)
        !drdy_n_o |=> drdy_n_o);

    // R4
    ready_to_send_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_READY) |=> (st_q == ST_SEND && cnt_q == '0));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SEND) |-> (cnt_q <= last));

    // R10
    share_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SEND) |-> $stable(share_q));
endmodule

// File: rtl/rtx_serializer.sv
`timescale 1ns/1ps
module rtx_serializer
    import rtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  sample_t           sample_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sending_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ser_en_n_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              fsync_n_o,
    output logic              latch_o
);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] word_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BIT_W-1:0]  bit_idx;
    logic [BIT_W-1:0]  sel;
    logic              own;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            addr_q <= '0;
        end else if (take_i) begin
            word_q <= build_word(sample_i, addr_i);
            addr_q <= addr_i;
        end
    end

    assign bit_idx   = cnt_i[BIT_W-1:0];
    assign sel       = TOP_BIT - bit_idx;
    assign own       = sending_i && (cnt_i[CNT_W-1:BIT_W] == addr_q);
    assign sdo_o     = own ? word_q[sel] : 1'b0;
    assign sdo_oe_o  = own && !ser_en_n_i;
    assign fsync_n_o = !own;
    assign latch_o   = own && (bit_idx[LATCH_W-1:0] == {LATCH_W{1'b1}});

    // R5
    fsync_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fsync_n_o) |-> (cnt_i[BIT_W-1:0] == '0));

    // R6
    latch_spaced_chk: assert property (@(posedge clk) disable iff (rst)
        latch_o |=> !latch_o);

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!fsync_n_o && cnt_i[BIT_W-1:0] == {BIT_W{1'b1}}) |-> !sdo_o);
endmodule

// File: rtl/rtx_top.sv
`timescale 1ns/1ps
module rtx_top
    import rtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RES_W-1:0]  res_i,
    input  logic              res_load_i,
    input  logic              dvalid_i,
    input  logic              ovr_i,
    input  logic              lpwr_i,
    input  logic              filt_ok_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [ADDR_W-1:0] share_i,
    input  logic              ser_en_n_i,
    output logic              ser_clk_o,
    output logic              drdy_n_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              fsync_n_o,
    output logic              latch_o
);
    sample_t          in_sample;
    sample_t          next_sample;
    logic             next_vld;
    logic             take;
    logic             sending;
    logic [CNT_W-1:0] cnt;

    assign in_sample.res           = res_i;
    assign in_sample.flags.dvalid  = dvalid_i;
    assign in_sample.flags.ovr     = ovr_i;
    assign in_sample.flags.lpwr    = lpwr_i;
    assign in_sample.flags.filt_ok = filt_ok_i;

    assign ser_clk_o = clk;

    rtx_load_buf u_buf (
        .clk        (clk),
        .rst        (rst),
        .load_i     (res_load_i),
        .sample_i   (in_sample),
        .take_i     (take),
        .next_vld_o (next_vld),
        .next_o     (next_sample)
    );

    rtx_slot_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .next_vld_i (next_vld),
        .share_i    (share_i),
        .take_o     (take),
        .drdy_n_o   (drdy_n_o),
        .sending_o  (sending),
        .cnt_o      (cnt)
    );

    rtx_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .take_i     (take),
        .sample_i   (next_sample),
        .addr_i     (dev_addr_i),
        .sending_i  (sending),
        .cnt_i      (cnt),
        .ser_en_n_i (ser_en_n_i),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o),
        .fsync_n_o  (fsync_n_o),
        .latch_o    (latch_o)
    );

    // R5
    fsync_no_drdy_chk: assert property (@(posedge clk) disable iff (rst)
        !drdy_n_o |-> fsync_n_o);

    // R2
    drdy_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drdy_n_o) |-> $past(next_vld));
endmodule

// File: tb/rtx_top_tb.sv
`timescale 1ns/1ps
module rtx_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] res_i = '0;
    logic        res_load_i = 1'b0;
    logic        dvalid_i = 1'b0, ovr_i = 1'b0, lpwr_i = 1'b0, filt_ok_i = 1'b0;
    logic [2:0]  dev_addr_i = '0;
    logic [2:0]  share_i = '0;
    logic        ser_en_n_i = 1'b0;
    logic        ser_clk_o, drdy_n_o, sdo_o, sdo_oe_o, fsync_n_o, latch_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtx_top u_dut (
        .clk(clk), .rst(rst), .res_i(res_i), .res_load_i(res_load_i),
        .dvalid_i(dvalid_i), .ovr_i(ovr_i), .lpwr_i(lpwr_i), .filt_ok_i(filt_ok_i),
        .dev_addr_i(dev_addr_i), .share_i(share_i), .ser_en_n_i(ser_en_n_i),
        .ser_clk_o(ser_clk_o), .drdy_n_o(drdy_n_o), .sdo_o(sdo_o),
        .sdo_oe_o(sdo_oe_o), .fsync_n_o(fsync_n_o), .latch_o(latch_o)
    );

    function automatic logic [31:0] mk_word(input logic [23:0] r, input logic [2:0] a,
                                            input logic [3:0] fl);
        return {r, a, fl, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_load(input logic [23:0] r, input logic [3:0] fl);
        res_i = r;
        {dvalid_i, ovr_i, lpwr_i, filt_ok_i} = fl;
        res_load_i = 1'b1;
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " drdy_n"}, 32'(drdy_n_o), 32'd1);
        chk({tag, " fsync_n"}, 32'(fsync_n_o), 32'd1);
        chk({tag, " oe"}, 32'(sdo_oe_o), 32'd0);
        chk({tag, " latch"}, 32'(latch_o), 32'd0);
    endtask

    // Called at the negedge where the ready pulse must be low.
    task automatic check_frame(input logic [31:0] w, input int a, input int sh,
                               input logic sen,
                               input int inj1_k, input logic [23:0] inj1_r, input logic [3:0] inj1_f,
                               input int inj2_k, input logic [23:0] inj2_r, input logic [3:0] inj2_f,
                               input int chg_k);
        int len;
        len = 32 * (sh + 1);
        res_load_i = 1'b0;
        chk("R2 ready cycle drdy_n", 32'(drdy_n_o), 32'd0);
        chk("R4 ready cycle oe", 32'(sdo_oe_o), 32'd0);
        for (int k = 0; k < len; k++) begin
            bit own;
            int lb;
            @(negedge clk);
            res_load_i = 1'b0;
            own = ((k / 32) == a);
            lb  = k % 32;
            chk("R2 drdy_n high in slots", 32'(drdy_n_o), 32'd1);
            chk("R5/R8 fsync_n", 32'(fsync_n_o), 32'(!own));
            chk("R4/R7 oe", 32'(sdo_oe_o), 32'(own && !sen));
            chk("R11 ser_clk low at falling edge", 32'(ser_clk_o), 32'd0);
            if (own) chk("R3 data bit", 32'(sdo_o), 32'(w[31 - lb]));
            chk("R6 latch", 32'(latch_o), 32'(own && (lb == 15 || lb == 31)));
            if (k == inj1_k) drive_load(inj1_r, inj1_f);
            if (k == inj2_k) drive_load(inj2_r, inj2_f);
            if (k == chg_k) begin
                share_i    = share_i + 3'd1;
                dev_addr_i = dev_addr_i + 3'd1;
            end
        end
        @(negedge clk);
        res_load_i = 1'b0;
    endtask

    task automatic simple_frame(input logic [23:0] r, input logic [3:0] fl, input int a,
                                input int sh, input logic sen);
        dev_addr_i = 3'(a);
        share_i    = 3'(sh);
        ser_en_n_i = sen;
        drive_load(r, fl);
        @(negedge clk);
        check_frame(mk_word(r, 3'(a), fl), a, sh, sen, -1, '0, '0, -1, '0, '0, -1);
        check_idle("R4 after frame");
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_idle("R1 reset");
        @(negedge clk);

        simple_frame(24'hA5C3F0, 4'b1010, 0, 0, 1'b0);
        simple_frame(24'h13579B, 4'b0101, 3, 3, 1'b0);
        // R8 address beyond share
        simple_frame(24'hFFFFFF, 4'b1111, 5, 2, 1'b0);
        // R7 output disabled
        simple_frame(24'h800001, 4'b1001, 1, 1, 1'b1);

        // R9 two loads during a transfer: the latest is sent next, with no gap
        dev_addr_i = 3'd0; share_i = 3'd1; ser_en_n_i = 1'b0;
        drive_load(24'h111111, 4'b1000);
        @(negedge clk);
        check_frame(mk_word(24'h111111, 3'd0, 4'b1000), 0, 1, 1'b0,
                    10, 24'h222222, 4'b0100, 40, 24'h333333, 4'b0010, -1);
        check_frame(mk_word(24'h333333, 3'd0, 4'b0010), 0, 1, 1'b0,
                    -1, '0, '0, -1, '0, '0, -1);
        check_idle("R9 after held frame");

        // R9 load on the last cycle of a transfer
        dev_addr_i = 3'd1; share_i = 3'd1;
        drive_load(24'hABCDEF, 4'b0001);
        @(negedge clk);
        check_frame(mk_word(24'hABCDEF, 3'd1, 4'b0001), 1, 1, 1'b0,
                    63, 24'h0F0F0F, 4'b1100, -1, '0, '0, -1);
        check_frame(mk_word(24'h0F0F0F, 3'd1, 4'b1100), 1, 1, 1'b0,
                    -1, '0, '0, -1, '0, '0, -1);
        check_idle("R9 after last-cycle load");

        // R10 share and address changed mid-transfer have no effect on it
        dev_addr_i = 3'd2; share_i = 3'd2;
        drive_load(24'h5A5A5A, 4'b0110);
        @(negedge clk);
        check_frame(mk_word(24'h5A5A5A, 3'd2, 4'b0110), 2, 2, 1'b0,
                    -1, '0, '0, -1, '0, '0, 5);
        check_idle("R10 after changed inputs");
        simple_frame(24'hC0FFEE, 4'b0011, 3, 3, 1'b0);

        // Random frames
        for (int i = 0; i < 24; i++) begin
            logic [23:0] r;
            logic [3:0]  fl;
            int a, sh;
            logic sen;
            r   = 24'($urandom);
            fl  = 4'($urandom);
            sh  = $urandom % 8;
            a   = (($urandom % 4) == 0) ? ($urandom % 8) : ($urandom % (sh + 1));
            sen = (($urandom % 4) == 0);
            simple_frame(r, fl, a, sh, sen);
            repeat ($urandom % 3) begin
                @(negedge clk);
                check_idle("R4 idle gap");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule